// File: doc/BRIEF.md
# SAR Conversion Timing Engine

This block sequences one successive-approximation conversion. A programmable prescaler divides the base clock into a slower unit clock. Every duration in the conversion is counted in units of that clock. After an accepted start, the block holds the sample switch closed for a programmed number of units. It then runs one bit trial per bit of the selected resolution, from the most significant bit downward. Each trial lasts a programmed number of units. During each trial the block presents the candidate code to the DAC and reads a single comparator bit.

The three timing settings sit in a small configuration register. They load through a strobe while the engine is idle, and they come out of reset with usable defaults. A compare setting of zero is illegal: a start request made with it is refused and flagged. Each conversion runs at 10-bit or 8-bit resolution, chosen at start. A stop input abandons the conversion at any point.

Top module: `sar_tmr_engine`

## Requirements
- R1: After reset the configuration holds division field 0 (ratio 1), sample setting 44 and compare setting 4. `busy`, `sample_en`, `done`, `cfg_err`, `trial_code` and `result` are all 0.
- R2: The unit clock is the base clock divided by (division field + 1), so field values 0..15 give ratios 1..16.
- R3: `sample_en` rises in the cycle after the start is accepted. It stays high for exactly S·(D+1) base cycles, where S is the sample setting and D the division field. A sample setting of 0 behaves as 1.
- R4: Each bit trial lasts C·(D+1) base cycles, where C is the compare setting. `done` appears (S + n·C)·(D+1) cycles after the cycle in which `busy` first reads 1, with n = 10 or 8.
- R5: A start request while the compare setting is 0 starts nothing. `cfg_err` is then high for exactly one cycle, and `busy` stays 0.
- R6: `busy` is high through the sample phase and every bit trial. It is low in the `done` cycle.
- R7: Trials run from the top bit downward. A trial bit is kept when `comp_in` is 1 in the last cycle of its trial. If the comparator reports vin ≥ code, the result equals vin, clamped to the largest code.
- R8: With `res8` = 1 at start, trials cover bits 7..0 only. `result[9:8]` and `trial_code[9:8]` read 0.
- R9: `stop` returns the engine to idle in the next cycle from any phase. No `done` pulse follows, and `result` keeps its previous value. `stop` in the same cycle as `start` blocks the start.
- R10: `done` is exactly one cycle wide. `result` carries the new value in that same cycle.
- R11: While busy, `cfg_load` and further `start` requests are ignored. The running conversion and the next one keep the earlier settings and timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load the three timing settings (idle only) |
| cfg_div | input | 4 | Division field, ratio = value + 1 |
| cfg_samp | input | 10 | Sample length in unit-clock periods |
| cfg_cmp | input | 6 | Per-bit trial length in unit-clock periods, 0 illegal |
| start | input | 1 | Start request, one cycle |
| stop | input | 1 | Abort request |
| res8 | input | 1 | 1 = 8-bit conversion, 0 = 10-bit, taken at start |
| comp_in | input | 1 | Comparator: 1 when input ≥ current trial code |
| sample_en | output | 1 | Sample switch enable |
| trial_code | output | 10 | DAC code under trial, 0 outside trials |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 10 | Last completed result, low-aligned |
| cfg_err | output | 1 | One-cycle flag for a refused start |

## Verification
Two functions can land in the same cycle, and the bench provokes both collisions on purpose.

The first is an abort arriving in the last cycle of the final bit trial, the cycle whose edge would otherwise raise `done`. The bench counts base cycles from the start so that `stop` is present exactly then. It then expects neither a `done` pulse nor a change in `result`, and it expects `busy` to drop.

The second is a new start or configuration load arriving mid-conversion. Here the bench expects the same finish cycle and result as an undisturbed run. It also expects the following conversion to keep the earlier timing.

// File: rtl/sar_tmr_pkg.sv
package sar_tmr_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE   = 2'd0,
    ENG_SAMPLE = 2'd1,
    ENG_TRIAL  = 2'd2
  } eng_state_t;
endpackage

// File: rtl/sar_tmr_timebase.sv
// Prescaler plus unit counter; flags the last base cycle of a phase or trial.
module sar_tmr_timebase #(
  parameter int DIV_W = 4,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic [CNT_W-1:0] limit,
  output logic             unit_end
);
  logic [DIV_W-1:0] pre;
  logic [CNT_W-1:0] units;
  logic             tick;

  assign tick     = run && (pre == div);
  // a limit of 0 ends after one unit, like a limit of 1
  assign unit_end = tick && (({1'b0, units} + (CNT_W+1)'(1)) >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre   <= '0;
      units <= '0;
    end else if (tick) begin
      pre   <= '0;
      units <= unit_end ? '0 : units + CNT_W'(1);
    end else begin
      pre   <= pre + DIV_W'(1);
    end
  end

  // R2: the prescaler never runs past the programmed ratio
  p_pre_bound_r2: assert property (@(posedge clk) disable iff (rst)
    run |-> (pre <= div));
endmodule

// File: rtl/sar_tmr_bits.sv
// Successive-approximation register: one-hot trial mask walking downward.
module sar_tmr_bits #(
  parameter int RES_W = 10,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [IDX_W-1:0] top_idx,
  input  logic             step,
  input  logic             comp,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] settled,
  output logic             last
);
  logic [RES_W-1:0] acc;
  logic [RES_W-1:0] mask;

  assign trial   = acc | mask;
  assign settled = comp ? (acc | mask) : acc;
  assign last    = mask[0];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc  <= '0;
      mask <= '0;
    end else if (load) begin
      acc  <= '0;
      mask <= RES_W'(1) << top_idx;
    end else if (step) begin
      acc  <= settled;
      mask <= mask >> 1;
    end
  end

  // R7: at most one bit is under trial at any time
  p_one_trial_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mask));
  // R7: a step that is not the last leaves exactly one bit under trial
  p_walk_down_r7: assert property (@(posedge clk) disable iff (rst)
    (step && !last && !clr) |=> ($countones(mask) == 1));
endmodule

// File: rtl/sar_tmr_engine.sv
module sar_tmr_engine #(
  parameter int DIV_W    = 4,
  parameter int SAMP_W   = 10,
  parameter int CMP_W    = 6,
  parameter int RES_W    = 10,
  parameter int NARROW_W = 8,
  parameter int SAMP_RST = 44,
  parameter int CMP_RST  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [SAMP_W-1:0] cfg_samp,
  input  logic [CMP_W-1:0]  cfg_cmp,
  input  logic              start,
  input  logic              stop,
  input  logic              res8,
  input  logic              comp_in,
  output logic              sample_en,
  output logic [RES_W-1:0]  trial_code,
  output logic              busy,
  output logic              done,
  output logic [RES_W-1:0]  result,
  output logic              cfg_err
);
  import sar_tmr_pkg::*;

  localparam int IDX_W = $clog2(RES_W);

  eng_state_t        state;
  logic [DIV_W-1:0]  div_q;
  logic [SAMP_W-1:0] samp_q;
  logic [CMP_W-1:0]  cmp_q;
  logic              res8_q;

  logic              idle, in_trial, start_ok, start_bad;
  logic              unit_end, step, last;
  logic [SAMP_W-1:0] limit;
  logic [IDX_W-1:0]  top_idx;
  logic [RES_W-1:0]  trial, settled;

  assign idle      = (state == ENG_IDLE);
  assign in_trial  = (state == ENG_TRIAL);
  assign start_ok  = idle && start && !stop && (cmp_q != '0);
  assign start_bad = idle && start && !stop && (cmp_q == '0);
  assign limit     = (state == ENG_SAMPLE) ? samp_q
                                           : {{(SAMP_W-CMP_W){1'b0}}, cmp_q};
  assign step      = in_trial && unit_end && !stop;
  assign top_idx   = res8 ? IDX_W'(NARROW_W-1) : IDX_W'(RES_W-1);
  assign trial_code = in_trial ? trial : '0;

  sar_tmr_timebase #(.DIV_W(DIV_W), .CNT_W(SAMP_W)) u_tb (
    .clk      (clk),
    .rst      (rst),
    .run      (!idle),
    .div      (div_q),
    .limit    (limit),
    .unit_end (unit_end)
  );

  sar_tmr_bits #(.RES_W(RES_W), .IDX_W(IDX_W)) u_bits (
    .clk     (clk),
    .rst     (rst),
    .clr     (stop),
    .load    (start_ok),
    .top_idx (top_idx),
    .step    (step),
    .comp    (comp_in),
    .trial   (trial),
    .settled (settled),
    .last    (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ENG_IDLE;
      busy      <= 1'b0;
      sample_en <= 1'b0;
      done      <= 1'b0;
      cfg_err   <= 1'b0;
      result    <= '0;
      res8_q    <= 1'b0;
      div_q     <= '0;
      samp_q    <= SAMP_W'(SAMP_RST);
      cmp_q     <= CMP_W'(CMP_RST);
    end else begin
      done    <= 1'b0;
      cfg_err <= start_bad;
      if (cfg_load && idle && !start) begin
        div_q  <= cfg_div;
        samp_q <= cfg_samp;
        cmp_q  <= cfg_cmp;
      end
      if (stop) begin
        state     <= ENG_IDLE;
        busy      <= 1'b0;
        sample_en <= 1'b0;
      end else begin
        unique case (state)
          ENG_IDLE: if (start_ok) begin
            state     <= ENG_SAMPLE;
            busy      <= 1'b1;
            sample_en <= 1'b1;
            res8_q    <= res8;
          end
          ENG_SAMPLE: if (unit_end) begin
            state     <= ENG_TRIAL;
            sample_en <= 1'b0;
          end
          ENG_TRIAL: if (unit_end && last) begin
            state  <= ENG_IDLE;
            busy   <= 1'b0;
            done   <= 1'b1;
            result <= settled;
          end
          default: state <= ENG_IDLE;
        endcase
      end
    end
  end

  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !sample_en));
  p_sample_busy_r3: assert property (@(posedge clk) disable iff (rst)
    sample_en |-> busy);
  p_stop_abort_r9: assert property (@(posedge clk) disable iff (rst)
    stop |=> (!busy && !done && !sample_en));
  p_err_refused_r5: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !busy);
  p_narrow_top_r8: assert property (@(posedge clk) disable iff (rst)
    (done && res8_q) |-> (result[RES_W-1:NARROW_W] == '0));
  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(div_q) && $stable(samp_q) && $stable(cmp_q)));
endmodule

// File: tb/sar_tmr_engine_test.sv
module sar_tmr_engine_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_load = 1'b0;
  logic [3:0] cfg_div = '0;
  logic [9:0] cfg_samp = '0;
  logic [5:0] cfg_cmp = '0;
  logic       start = 1'b0;
  logic       stop = 1'b0;
  logic       res8 = 1'b0;
  logic       comp_in;
  logic       sample_en, busy, done, cfg_err;
  logic [9:0] trial_code, result;

  int vin = 0;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  always_comb comp_in = (vin >= int'(trial_code));

  sar_tmr_engine uut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_div(cfg_div),
    .cfg_samp(cfg_samp), .cfg_cmp(cfg_cmp), .start(start), .stop(stop),
    .res8(res8), .comp_in(comp_in), .sample_en(sample_en),
    .trial_code(trial_code), .busy(busy), .done(done), .result(result),
    .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int d, input int s, input int c);
    @(negedge clk);
    cfg_load = 1'b1; cfg_div = 4'(d); cfg_samp = 10'(s); cfg_cmp = 6'(c);
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // leaves the bench at the negedge after the start edge (k = 0)
  task automatic begin_conv(input int v, input bit r8);
    @(negedge clk);
    vin = v; res8 = r8; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic scan(input int k0, input int expN, input int expS,
                      input int expR, input string req);
    int k; int scnt; int dk; bit busy_ok;
    k = k0; scnt = 0; dk = -1; busy_ok = 1'b1;
    while (dk < 0 && k <= expN + 4) begin
      if (sample_en) scnt++;
      if (done) dk = k;
      if (busy != (dk < 0)) busy_ok = 1'b0;
      if (dk < 0) begin
        @(negedge clk);
        k++;
      end
    end
    chk(dk == expN, {req, " done cycle"}, dk, expN);
    chk(scnt == expS, {req, " R3 sample length"}, scnt, expS);
    chk(int'(result) == expR, {req, " result"}, int'(result), expR);
    chk(busy_ok, {req, " R6 busy window"}, int'(busy_ok), 1);
    @(negedge clk);
    chk(!done, {req, " R10 single pulse"}, int'(done), 0);
  endtask

  function automatic int clampv(input int v, input bit r8);
    int mx;
    mx = r8 ? 255 : 1023;
    return (v > mx) ? mx : v;
  endfunction

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int prev;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !sample_en && !done && !cfg_err, "R1 idle flags", int'(busy), 0);
    chk(trial_code == '0 && result == '0, "R1 zero codes", int'(result), 0);

    // R1 defaults D=0 S=44 C=4, R4 timing
    begin_conv(700, 1'b0);
    scan(0, 84, 44, 700, "R1 R4 defaults");

    // R7 R8 exhaustive 8-bit sweep
    set_cfg(0, 1, 1);
    for (int v = 0; v <= 256; v++) begin
      begin_conv(v, 1'b1);
      scan(0, 9, 1, clampv(v, 1'b1), "R7 R8 narrow");
    end
    begin_conv(300, 1'b1);
    scan(0, 9, 1, 255, "R8 narrow clamp");

    // R7 exhaustive 10-bit sweep
    for (int v = 0; v <= 1023; v++) begin
      begin_conv(v, 1'b0);
      scan(0, 11, 1, v, "R7 wide");
    end
    begin_conv(1500, 1'b0);
    scan(0, 11, 1, 1023, "R7 wide clamp");

    // R2 every division ratio
    for (int d = 0; d < 16; d++) begin
      set_cfg(d, 2, 1);
      begin_conv(d * 13, 1'b1);
      scan(0, 10 * (d + 1), 2 * (d + 1), d * 13, "R2 divider");
    end

    // R4 multi-unit trials, R3 sample setting 0 acts as 1
    set_cfg(1, 3, 2);
    begin_conv(613, 1'b0);
    scan(0, 46, 6, 613, "R4 long trials");
    set_cfg(0, 0, 2);
    begin_conv(77, 1'b1);
    scan(0, 17, 1, 77, "R3 zero sample");

    // R5 illegal compare setting
    set_cfg(0, 2, 0);
    begin_conv(10, 1'b0);
    chk(cfg_err == 1'b1, "R5 flag raised", int'(cfg_err), 1);
    chk(!busy && !sample_en, "R5 no start", int'(busy), 0);
    @(negedge clk);
    chk(cfg_err == 1'b0, "R5 flag one cycle", int'(cfg_err), 0);
    chk(!busy, "R5 still idle", int'(busy), 0);

    // R9 stop during sample
    set_cfg(0, 1, 1);
    prev = int'(result);
    begin_conv(400, 1'b0);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(!busy && !sample_en && trial_code == '0, "R9 stop in sample", int'(busy), 0);
    // R9 stop during trials
    begin_conv(400, 1'b0);
    repeat (4) @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(!busy && trial_code == '0, "R9 stop in trial", int'(busy), 0);
    // R9 stop collides with the final trial edge
    begin_conv(400, 1'b0);
    repeat (10) @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(!done, "R9 no done on abort", int'(done), 0);
    chk(!busy, "R9 idle after abort", int'(busy), 0);
    chk(int'(result) == prev, "R9 result kept", int'(result), prev);
    begin
      bit seen;
      seen = 1'b0;
      for (int i = 0; i < 15; i++) begin
        @(negedge clk);
        if (done) seen = 1'b1;
      end
      chk(!seen, "R9 no late done", int'(seen), 0);
    end
    // R9 stop beats start
    @(negedge clk);
    start = 1'b1; stop = 1'b1;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    chk(!busy && !sample_en, "R9 stop blocks start", int'(busy), 0);

    // R11 start and load while busy are ignored
    begin_conv(500, 1'b0);
    start = 1'b1; cfg_load = 1'b1; cfg_div = 4'd5; cfg_samp = 10'd9; cfg_cmp = 6'd9;
    @(negedge clk);
    start = 1'b0; cfg_load = 1'b0;
    scan(1, 11, 0, 500, "R11 busy retrigger");
    begin_conv(321, 1'b0);
    scan(0, 11, 1, 321, "R11 settings kept");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule